// File: doc/BRIEF.md
# XOR Channel Index Hash

This block scrambles the memory channel index of an address that has already been split into row, bank and column fields. It is meant for a memory system with 32 channels. Each of the five bits of the channel index is XORed with a fixed group of low row-address bits. Addresses that differ only in their row then land on different channels instead of crowding onto one.

The caller presents a row field, a 5-bit channel field and a valid strobe, together with the configured channel count. One clock later the block returns the hashed channel index, a copy of the row and a valid strobe. The hash is only defined for a count of 32. Any other count raises an error flag, and the channel index is then passed through unchanged.

Top module: `chan_xor_hash`

## Requirements
- R1: Hashed channel bit 0 is the XOR of input channel bit 0 with row bits 0, 3, 5, 6, 9, 10, 11, 12 and 13.
- R2: Hashed channel bit 1 is the XOR of input channel bit 1 with row bits 1, 4, 6, 7, 10, 11, 12, 13 and 14.
- R3: Hashed channel bit 2 is the XOR of input channel bit 2 with row bits 0, 2, 3, 6, 7, 8, 9, 10 and 14.
- R4: Hashed channel bit 3 is the XOR of input channel bit 3 with row bits 1, 3, 4, 7, 8, 9, 10 and 11.
- R5: Hashed channel bit 4 is the XOR of input channel bit 4 with row bits 2, 4, 5, 8, 9, 10, 11 and 12.
- R6: When the configured channel count equals 32, the hash of R1 to R5 is applied and `hash_err` is 0 one cycle later.
- R7: When the configured channel count is any value other than 32, `hash_err` is 1 one cycle later, and a request accepted in that cycle returns its input channel unchanged.
- R8: `hash_valid` equals `req_valid` delayed by exactly one clock. The outputs `hash_chan` and `hash_row` update only for a valid request and hold otherwise.
- R9: `hash_row` returns the request row unchanged. Row bits above bit 14 have no effect on `hash_chan`.
- R10: For any fixed row value, the 32 input channel values map to 32 distinct hashed channel values.
- R11: While reset is active, `hash_valid`, `hash_err`, `hash_chan` and `hash_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_row | input | ROW_W (16) | Row field of the decoded address |
| req_chan | input | 5 | Channel field before hashing |
| cfg_chan_count | input | CNT_W (8) | Configured number of memory channels |
| hash_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| hash_chan | output | 5 | Hashed channel index (unchanged when the count is unsupported) |
| hash_row | output | ROW_W (16) | Row field passed through |
| hash_err | output | 1 | Configured channel count is not 32 |

## Verification
Every result is due exactly one rising edge after it is presented. This covers the hashed channel, the row copy, the valid strobe and the error flag, which reflects the count seen at that edge. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. Each check therefore reads the registered result of the request driven half a cycle earlier. After a request, the bench idles the strobe for one cycle and confirms that the valid output drops while the data outputs hold.

// File: rtl/chash_pkg.sv
package chash_pkg;

   // Number of low row bits that take part in the hash
   localparam int HASH_SPAN = 15;
   // Channel index width for the 32-channel hash
   localparam int CHAN_W    = 5;
   // Channel count for which the hash is defined
   localparam int HASH_CHANNELS = 1 << CHAN_W;

   typedef logic [HASH_SPAN-1:0] span_t;
   typedef logic [CHAN_W-1:0]    chan_t;

   // Row-bit selection mask per hashed channel bit
   function automatic span_t hash_mask(input int unsigned chan_bit);
      span_t m;
      case (chan_bit)
         0:       m = 15'h3E69;
         1:       m = 15'h7CD2;
         2:       m = 15'h47CD;
         3:       m = 15'h0F9A;
         4:       m = 15'h1F34;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/chash_mask_net.sv
module chash_mask_net
   import chash_pkg::*;
(
   input  span_t row_lo,
   input  chan_t chan_in,
   output chan_t chan_out
);

   for (genvar b = 0; b < CHAN_W; b++) begin : g_bit
      localparam span_t SEL = hash_mask(b);
      logic fold;
      assign fold        = ^(row_lo & SEL);
      assign chan_out[b] = chan_in[b] ^ fold;
   end

   // The mask net must be a pure XOR: hashing twice with the same row restores the input
   chan_t twice;
   for (genvar b = 0; b < CHAN_W; b++) begin : g_twice
      assign twice[b] = chan_out[b] ^ (^(row_lo & hash_mask(b)));
   end
   always_comb begin
      AST_HASH_INVERTIBLE: assert (twice == chan_in); // R10
   end

endmodule

// File: rtl/chash_cfg_check.sv
module chash_cfg_check #(
   parameter int CNT_W     = 8,
   parameter int SUPPORTED = 32
) (
   input  logic [CNT_W-1:0] chan_count,
   output logic             unsupported
);

   localparam logic [CNT_W-1:0] SUP_VAL = CNT_W'(SUPPORTED);

   if (SUPPORTED >= (1 << CNT_W)) begin : g_bad_width
      $error("chash_cfg_check: CNT_W too narrow for the supported channel count");
   end

   assign unsupported = (chan_count != SUP_VAL);

endmodule

// File: rtl/chash_out_stage.sv
module chash_out_stage
   import chash_pkg::*;
#(
   parameter int ROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [ROW_W-1:0] in_row,
   input  chan_t            raw_chan,
   input  chan_t            mixed_chan,
   input  logic             unsupported,
   output logic             q_valid,
   output logic [ROW_W-1:0] q_row,
   output chan_t            q_chan,
   output logic             q_err
);

   chan_t sel_chan;
   assign sel_chan = unsupported ? raw_chan : mixed_chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_err   <= 1'b0;
         q_chan  <= '0;
         q_row   <= '0;
      end else begin
         q_valid <= in_valid;
         q_err   <= unsupported;
         if (in_valid) begin
            q_chan <= sel_chan;
            q_row  <= in_row;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> q_valid); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!q_valid && $stable(q_chan) && $stable(q_row))); // R8
   AST_UNSUP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && unsupported) |=> (q_err && q_chan == $past(raw_chan))); // R7
   AST_SUP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !unsupported |=> !q_err); // R6

endmodule

// File: rtl/chan_xor_hash.sv
module chan_xor_hash
   import chash_pkg::*;
#(
   parameter int ROW_W = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [ROW_W-1:0] req_row,
   input  logic [4:0]       req_chan,
   input  logic [CNT_W-1:0] cfg_chan_count,
   output logic             hash_valid,
   output logic [4:0]       hash_chan,
   output logic [ROW_W-1:0] hash_row,
   output logic             hash_err
);

   if (ROW_W < HASH_SPAN) begin : g_row_too_narrow
      $error("chan_xor_hash: ROW_W must cover at least the hashed row span");
   end

   chan_t mixed;
   logic  unsup;

   chash_mask_net u_net (
      .row_lo   (req_row[HASH_SPAN-1:0]),
      .chan_in  (req_chan),
      .chan_out (mixed)
   );

   chash_cfg_check #(
      .CNT_W     (CNT_W),
      .SUPPORTED (HASH_CHANNELS)
   ) u_cfg (
      .chan_count  (cfg_chan_count),
      .unsupported (unsup)
   );

   chash_out_stage #(
      .ROW_W (ROW_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (req_valid),
      .in_row      (req_row),
      .raw_chan    (req_chan),
      .mixed_chan  (mixed),
      .unsupported (unsup),
      .q_valid     (hash_valid),
      .q_row       (hash_row),
      .q_chan      (hash_chan),
      .q_err       (hash_err)
   );

   AST_ROW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> hash_row == $past(req_row)); // R9

endmodule

// File: tb/test_chan_xor_hash.sv
module test_chan_xor_hash;

   localparam int ROW_W = 16;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [ROW_W-1:0] req_row = '0;
   logic [4:0]       req_chan = '0;
   logic [CNT_W-1:0] cfg_chan_count = 8'd32;
   logic             hash_valid;
   logic [4:0]       hash_chan;
   logic [ROW_W-1:0] hash_row;
   logic             hash_err;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   chan_xor_hash #(.ROW_W(ROW_W), .CNT_W(CNT_W)) i_chan_xor_hash (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
      .req_chan(req_chan), .cfg_chan_count(cfg_chan_count),
      .hash_valid(hash_valid), .hash_chan(hash_chan), .hash_row(hash_row),
      .hash_err(hash_err)
   );

   // Expected hash, written from the bit lists of R1..R5
   function automatic logic [4:0] model(input logic [ROW_W-1:0] r, input logic [4:0] c);
      logic [4:0] h;
      h[0] = c[0] ^ r[0] ^ r[3] ^ r[5] ^ r[6] ^ r[9] ^ r[10] ^ r[11] ^ r[12] ^ r[13];
      h[1] = c[1] ^ r[1] ^ r[4] ^ r[6] ^ r[7] ^ r[10] ^ r[11] ^ r[12] ^ r[13] ^ r[14];
      h[2] = c[2] ^ r[0] ^ r[2] ^ r[3] ^ r[6] ^ r[7] ^ r[8] ^ r[9] ^ r[10] ^ r[14];
      h[3] = c[3] ^ r[1] ^ r[3] ^ r[4] ^ r[7] ^ r[8] ^ r[9] ^ r[10] ^ r[11];
      h[4] = c[4] ^ r[2] ^ r[4] ^ r[5] ^ r[8] ^ r[9] ^ r[10] ^ r[11] ^ r[12];
      return h;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive one request on the falling edge, sample 1 time unit after the next rising edge
   task automatic send(input logic [ROW_W-1:0] r, input logic [4:0] c, input logic [CNT_W-1:0] n);
      @(negedge clk);
      req_valid = 1'b1;
      req_row = r;
      req_chan = c;
      cfg_chan_count = n;
      @(posedge clk);
      #1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Check each hashed bit against its own requirement (R1..R5) plus R6
   task automatic check_hash(input logic [ROW_W-1:0] r, input logic [4:0] c);
      logic [4:0] e;
      string tags [5];
      tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4"; tags[4] = "R5";
      e = model(r, c);
      for (int b = 0; b < 5; b++)
         check(hash_chan[b] == e[b], tags[b], $sformatf("bit%0d row=%h chan=%0d", b, r, c),
               32'(hash_chan[b]), 32'(e[b]));
      check(hash_err == 1'b0 && hash_valid, "R6", "err low / valid with count 32",
            {30'd0, hash_err, hash_valid}, 32'd1);
   endtask

   initial begin
      // R11 reset state
      #2;
      check(hash_valid == 1'b0, "R11", "valid in reset", 32'(hash_valid), 0);
      check(hash_err == 1'b0, "R11", "err in reset", 32'(hash_err), 0);
      check(hash_chan == '0, "R11", "chan in reset", 32'(hash_chan), 0);
      check(hash_row == '0, "R11", "row in reset", 32'(hash_row), 0);
      repeat (3) @(posedge clk);
      #1;
      check(hash_valid == 1'b0 && hash_chan == '0, "R11", "held in reset",
            {26'd0, hash_valid, hash_chan}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Single row bit patterns: each exercises one column of R1..R5
      for (int k = 0; k < ROW_W; k++) begin
         send(ROW_W'(1) << k, 5'd0, 8'd32);
         check_hash(ROW_W'(1) << k, 5'd0);
      end
      send('0, 5'd31, 8'd32);
      check_hash('0, 5'd31);
      send('1, 5'd0, 8'd32);
      check_hash('1, 5'd0);

      // R9: bits above 14 ignored, row returned unchanged
      begin
         logic [4:0] first;
         send(16'h1234, 5'd9, 8'd32);
         first = hash_chan;
         check(hash_row == 16'h1234, "R9", "row passthrough", 32'(hash_row), 32'h1234);
         send(16'h9234, 5'd9, 8'd32);
         check(hash_chan == first, "R9", "bit15 no effect", 32'(hash_chan), 32'(first));
         check(hash_row == 16'h9234, "R9", "row passthrough high", 32'(hash_row), 32'h9234);
      end

      // R8: valid drops while data holds
      begin
         logic [4:0] keep;
         logic [ROW_W-1:0] keep_row;
         send(16'h0ABC, 5'd3, 8'd32);
         keep = hash_chan;
         keep_row = hash_row;
         check(hash_valid == 1'b1, "R8", "valid one cycle later", 32'(hash_valid), 1);
         req_row = 16'h7FFF;
         req_chan = 5'd17;
         @(posedge clk);
         #1;
         check(hash_valid == 1'b0, "R8", "valid drops when idle", 32'(hash_valid), 0);
         check(hash_chan == keep && hash_row == keep_row, "R8", "data hold when idle",
               32'({hash_chan, hash_row}), 32'({keep, keep_row}));
      end

      // R10: bijection over all 32 channels for several rows
      for (int t = 0; t < 4; t++) begin
         logic [ROW_W-1:0] r;
         logic [31:0] seen;
         seen = '0;
         r = (t == 0) ? '0 : ROW_W'($urandom);
         for (int c = 0; c < 32; c++) begin
            send(r, 5'(c), 8'd32);
            seen[hash_chan] = 1'b1;
         end
         check(seen == 32'hFFFF_FFFF, "R10", $sformatf("distinct outputs row=%h", r),
               seen, 32'hFFFF_FFFF);
      end

      // R7: unsupported counts raise the error and pass the channel through
      begin
         logic [CNT_W-1:0] bad [4];
         bad[0] = 8'd16; bad[1] = 8'd64; bad[2] = 8'd0; bad[3] = 8'd31;
         for (int i = 0; i < 4; i++) begin
            send(16'h5A5A, 5'd21, bad[i]);
            check(hash_err == 1'b1, "R7", $sformatf("err for count %0d", bad[i]),
                  32'(hash_err), 1);
            check(hash_chan == 5'd21, "R7", "channel unchanged", 32'(hash_chan), 21);
         end
         // Back to 32: error clears next cycle (R6)
         send(16'h5A5A, 5'd21, 8'd32);
         check_hash(16'h5A5A, 5'd21);
      end

      // Constrained random stimulus, fixed seed
      void'($urandom(32'h1357));
      for (int n = 0; n < 300; n++) begin
         logic [ROW_W-1:0] r;
         logic [4:0] c;
         r = ROW_W'($urandom);
         c = 5'($urandom);
         send(r, c, 8'd32);
         check_hash(r, c);
         check(hash_row == r, "R9", "random row passthrough", 32'(hash_row), 32'(r));
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule